// File: doc/BRIEF.md
# Code Word Status Bit Generator

This block builds the five status bits that close every transmitted code word of a rolling-code remote encoder. The five bits are a low-battery flag, a two-bit field and a two-bit press-queue count. A select input chooses what the two-bit field carries: a two-bit serial checksum of the word's leading bits, or a measure of how long the buttons have been held. The transmitter's serializer feeds the block each outgoing bit with a valid strobe, and pulses a word-start input at the beginning of each code word. The block keeps the checksum in step with the stream. When the serializer reaches the tail of the word, it shifts out `status_bits` least significant bit first.

A free-running tick times the hold-time bits and the press-queue window. All timing parameters count ticks; with the defaults the tick is 0.1 ms. The queue counter records quick repeated presses of the same button combination. When a repeat press is found, the block raises a one-cycle terminate pulse so the transmitter can cut the current word short. The analog supply comparator is outside the block. Only its digital level enters here.

Top module: `stgen_status`

## Requirements
- R1: A word-start pulse clears the checksum to 00. Each valid bit then updates it, for the first CRC_BITS (65) valid bits after word start only; later bits are ignored. The update for data bit D is new[1] = old[0] XOR D and new[0] = old[0] XOR D XOR old[1]. A word-start pulse takes priority over a valid bit in the same cycle.
- R2: `status_bits[2:1]` carries the checksum when `crc_sel` is 1 and the hold-time bits when `crc_sel` is 0, with bit 1 as the lower bit of either field.
- R3: `status_bits[0]` is the level of `lowv_lvl` captured on the word-start pulse. It holds that value until the next word start, whatever `lowv_lvl` does in between.
- R4: The hold-time bits are 00 whenever no button is pressed. While any button stays pressed they count up by one every TIME_STEP_TICKS ticks and saturate at 11.
- R5: `status_bits[4:3]` (bit 3 lower) is the queue count. When the same non-zero combination is pressed again, and this is seen at a window sample within QWIN_TICKS ticks after release, the count goes up by one. The count saturates at 11.
- R6: A counted repeat press produces exactly one cycle of `queue_abort`, in the cycle after the sampling tick.
- R7: If the window expires without a repeat press, the queue count returns to 00.
- R8: A different non-zero combination seen at a window sample resets the queue count to 00 and raises no `queue_abort`.
- R9: Inside the window, buttons are looked at only on every QSAMP_TICKS-th tick. A press that is released again between two samples has no effect on the queue count.
- R10: After reset, `status_bits` is 00000 and `queue_abort` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_start | input | 1 | One-cycle pulse at the start of a code word |
| bit_valid | input | 1 | Strobe qualifying `bit_data` |
| bit_data | input | 1 | Transmitted bit, in transmit order |
| lowv_lvl | input | 1 | Supply comparator output, 1 = below threshold |
| buttons | input | NBTN | Debounced button levels |
| crc_sel | input | 1 | 1 = checksum field, 0 = hold-time field |
| tick | input | 1 | Timebase strobe, one cycle wide |
| status_bits | output | 5 | {queue[1:0], field[1:0], low-battery} |
| queue_abort | output | 1 | Terminate pulse for a queued repeat press |

## Verification
The checksum is tried with three streams: an alternating pattern, an irregular pattern and all ones. Each stream is longer than 65 bits, so the trailing bits also show whether the block stops updating at the limit. The queue tracker is driven through repeated same-combination presses up to saturation. It is also given a quiet window that runs to expiry, a different combination, and a short press that falls between two samples; these four cases separate counting, clearing, restarting and sample gating. A held press running past three time steps shows the hold-time bits saturating, and releasing the buttons clears them. Raising the comparator level after the word-start pulse shows whether the flag is captured or simply passed through.

// File: rtl/stgen_pkg.sv
package stgen_pkg;
  typedef enum logic [1:0] {
    QS_IDLE   = 2'd0,
    QS_HELD   = 2'd1,
    QS_WINDOW = 2'd2
  } qstate_e;
  localparam int STATUS_W = 5;
endpackage

// File: rtl/stgen_crc.sv
module stgen_crc #(
  parameter int CRC_BITS = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       word_start,
  input  logic       bit_valid,
  input  logic       bit_data,
  output logic [1:0] crc
);
  localparam int CW = $clog2(CRC_BITS + 1);
  localparam logic [CW-1:0] CNT_LIMIT = CW'(CRC_BITS);

  logic [1:0]    crc_q, crc_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          fold;

  always_comb begin
    crc_n = crc_q;
    cnt_n = cnt_q;
    fold  = crc_q[0] ^ bit_data;
    if (word_start) begin
      crc_n = 2'b00;
      cnt_n = '0;
    end else if (bit_valid && (cnt_q < CNT_LIMIT)) begin
      crc_n[1] = fold;
      crc_n[0] = fold ^ crc_q[1];
      cnt_n    = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= 2'b00;
      cnt_q <= '0;
    end else begin
      crc_q <= crc_n;
      cnt_q <= cnt_n;
    end
  end

  assign crc = crc_q;
endmodule

// File: rtl/stgen_hold.sv
module stgen_hold #(
  parameter int NBTN            = 4,
  parameter int TIME_STEP_TICKS = 8000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBTN-1:0] buttons,
  input  logic            tick,
  output logic [1:0]      time_bits
);
  localparam int CW = $clog2(TIME_STEP_TICKS + 1);
  localparam logic [CW-1:0] STEP_LAST = CW'(TIME_STEP_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic [1:0]    tb_q, tb_n;

  always_comb begin
    cnt_n = cnt_q;
    tb_n  = tb_q;
    if (buttons == '0) begin
      cnt_n = '0;
      tb_n  = 2'b00;
    end else if (tick) begin
      if (cnt_q == STEP_LAST) begin
        cnt_n = '0;
        if (tb_q != 2'b11) tb_n = tb_q + 2'b01;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tb_q  <= 2'b00;
    end else begin
      cnt_q <= cnt_n;
      tb_q  <= tb_n;
    end
  end

  assign time_bits = tb_q;
endmodule

// File: rtl/stgen_queue.sv
module stgen_queue
  import stgen_pkg::*;
#(
  parameter int NBTN        = 4,
  parameter int QWIN_TICKS  = 20000,
  parameter int QSAMP_TICKS = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBTN-1:0] buttons,
  input  logic            tick,
  output logic [1:0]      q_count,
  output logic            abort
);
  localparam int WW = $clog2(QWIN_TICKS + 1);
  localparam int SW = $clog2(QSAMP_TICKS + 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(QWIN_TICKS - 1);
  localparam logic [SW-1:0] SMP_LAST = SW'(QSAMP_TICKS - 1);

  qstate_e       st_q, st_n;
  logic [WW-1:0] win_q, win_n;
  logic [SW-1:0] smp_q, smp_n;
  logic [NBTN-1:0] combo_q, combo_n;
  logic [1:0]    cnt_q, cnt_n;
  logic          abort_q, abort_n;
  logic          any_btn;

  assign any_btn = (buttons != '0);

  always_comb begin
    st_n    = st_q;
    win_n   = win_q;
    smp_n   = smp_q;
    combo_n = combo_q;
    cnt_n   = cnt_q;
    abort_n = 1'b0;
    if (any_btn && (st_q != QS_WINDOW)) combo_n = buttons;
    unique case (st_q)
      QS_IDLE: begin
        if (any_btn) st_n = QS_HELD;
      end
      QS_HELD: begin
        if (!any_btn) begin
          st_n  = QS_WINDOW;
          win_n = '0;
          smp_n = '0;
        end
      end
      QS_WINDOW: begin
        if (tick) begin
          win_n = win_q + 1'b1;
          smp_n = smp_q + 1'b1;
          if ((smp_q == SMP_LAST) && any_btn) begin
            st_n = QS_HELD;
            if (buttons == combo_q) begin
              if (cnt_q != 2'b11) cnt_n = cnt_q + 2'b01;
              abort_n = 1'b1;
            end else begin
              cnt_n = 2'b00;
            end
          end else begin
            if (smp_q == SMP_LAST) smp_n = '0;
            if (win_q == WIN_LAST) begin
              st_n  = QS_IDLE;
              cnt_n = 2'b00;
            end
          end
        end
      end
      default: st_n = QS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= QS_IDLE;
      win_q   <= '0;
      smp_q   <= '0;
      combo_q <= '0;
      cnt_q   <= 2'b00;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      win_q   <= win_n;
      smp_q   <= smp_n;
      combo_q <= combo_n;
      cnt_q   <= cnt_n;
      abort_q <= abort_n;
    end
  end

  assign q_count = cnt_q;
  assign abort   = abort_q;
endmodule

// File: rtl/stgen_status.sv
module stgen_status
  import stgen_pkg::*;
#(
  parameter int NBTN            = 4,
  parameter int CRC_BITS        = 65,
  parameter int TIME_STEP_TICKS = 8000,
  parameter int QWIN_TICKS      = 20000,
  parameter int QSAMP_TICKS     = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            word_start,
  input  logic            bit_valid,
  input  logic            bit_data,
  input  logic            lowv_lvl,
  input  logic [NBTN-1:0] buttons,
  input  logic            crc_sel,
  input  logic            tick,
  output logic [4:0]      status_bits,
  output logic            queue_abort
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [1:0] crc_val;
  logic [1:0] time_val;
  logic [1:0] q_val;
  logic       lowbat_q, lowbat_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  stgen_crc #(.CRC_BITS(CRC_BITS)) i_crc (
    .clk(clk), .rst_n(rst_int_n), .word_start(word_start),
    .bit_valid(bit_valid), .bit_data(bit_data), .crc(crc_val)
  );

  stgen_hold #(.NBTN(NBTN), .TIME_STEP_TICKS(TIME_STEP_TICKS)) i_hold (
    .clk(clk), .rst_n(rst_int_n), .buttons(buttons), .tick(tick),
    .time_bits(time_val)
  );

  stgen_queue #(.NBTN(NBTN), .QWIN_TICKS(QWIN_TICKS),
                .QSAMP_TICKS(QSAMP_TICKS)) i_queue (
    .clk(clk), .rst_n(rst_int_n), .buttons(buttons), .tick(tick),
    .q_count(q_val), .abort(queue_abort)
  );

  always_comb begin
    lowbat_n = lowbat_q;
    if (word_start) lowbat_n = lowv_lvl;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) lowbat_q <= 1'b0;
    else            lowbat_q <= lowbat_n;
  end

  assign status_bits = {q_val, (crc_sel ? crc_val : time_val), lowbat_q};
endmodule

// File: rtl/stgen_status_chk.sv
module stgen_status_chk #(
  parameter int NBTN = 4
) (
  input logic            clk,
  input logic            rst_int_n,
  input logic            word_start,
  input logic [NBTN-1:0] buttons,
  input logic [1:0]      crc_val,
  input logic [1:0]      time_val,
  input logic [1:0]      q_val,
  input logic            lowbat_q,
  input logic            queue_abort
);
  // R1: checksum cleared after word start
  assert_crc_clear_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    word_start |=> (crc_val == 2'b00));

  // R3: flag only moves on word start
  assert_lowbat_hold_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    !word_start |=> $stable(lowbat_q));

  // R4: no button means zero hold time
  assert_time_clear_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (buttons == '0) |=> (time_val == 2'b00));

  // R4: hold time steps by at most one
  assert_time_step_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (time_val == 2'b00 || time_val == $past(time_val) ||
              time_val == $past(time_val) + 2'b01));

  // R5: queue count moves by one or clears
  assert_queue_step_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (q_val == 2'b00 || q_val == $past(q_val) ||
              q_val == $past(q_val) + 2'b01));

  // R6: terminate is a single-cycle pulse
  assert_abort_pulse_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    queue_abort |=> !queue_abort);

  // R6: terminate accompanies a count that is non-zero
  assert_abort_count_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    queue_abort |-> (q_val != 2'b00));
endmodule

bind stgen_status stgen_status_chk #(.NBTN(NBTN)) i_chk (
  .clk(clk), .rst_int_n(rst_int_n), .word_start(word_start),
  .buttons(buttons), .crc_val(crc_val), .time_val(time_val),
  .q_val(q_val), .lowbat_q(lowbat_q), .queue_abort(queue_abort)
);

// File: tb/test_stgen_status.sv
module test_stgen_status;
  localparam int NB = 4;
  localparam int STEP = 4;
  localparam int QWIN = 24;
  localparam int QSMP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_start = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
  logic lowv_lvl = 1'b0, crc_sel = 1'b0, tick = 1'b0;
  logic [NB-1:0] buttons = '0;
  logic [4:0] status_bits;
  logic queue_abort;

  int n_checks = 0;
  int n_fail = 0;
  int aborts = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  stgen_status #(.NBTN(NB), .CRC_BITS(65), .TIME_STEP_TICKS(STEP),
                 .QWIN_TICKS(QWIN), .QSAMP_TICKS(QSMP)) i_stgen_status (
    .clk(clk), .rst_n(rst_n), .word_start(word_start), .bit_valid(bit_valid),
    .bit_data(bit_data), .lowv_lvl(lowv_lvl), .buttons(buttons),
    .crc_sel(crc_sel), .tick(tick), .status_bits(status_bits),
    .queue_abort(queue_abort)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic give_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (queue_abort) aborts++;
      @(negedge clk);
      if (queue_abort) aborts++;
    end
  endtask

  function automatic logic [1:0] ref_crc(input logic [79:0] v, input int n);
    logic [1:0] c = 2'b00;
    for (int i = 0; i < n && i < 65; i++) begin
      logic f = c[0] ^ v[i];
      c = {f, f ^ c[1]};
    end
    return c;
  endfunction

  task automatic send_word(input logic [79:0] v, input int n);
    word_start = 1'b1;
    @(negedge clk);
    word_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      bit_valid = 1'b1;
      bit_data  = v[i];
      @(negedge clk);
    end
    bit_valid = 1'b0;
    bit_data  = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 status after reset", int'(status_bits), 0);
    check("R10 abort after reset", int'(queue_abort), 0);
  endtask

  task automatic t_crc;
    logic [79:0] pats [3];
    pats[0] = {40{2'b10}};
    for (int i = 0; i < 80; i++) pats[1][i] = ((i * 7 + 3) % 5) < 2;
    pats[2] = '1;
    crc_sel = 1'b1;
    for (int p = 0; p < 3; p++) begin
      send_word(pats[p], 70);
      check("R1 checksum after 70 bits (first 65 counted)",
            int'(status_bits[2:1]), int'(ref_crc(pats[p], 65)));
    end
    send_word(pats[1], 30);
    check("R1 checksum on partial word", int'(status_bits[2:1]),
          int'(ref_crc(pats[1], 30)));
    word_start = 1'b1;
    @(negedge clk);
    word_start = 1'b0;
    check("R1 word start clears checksum", int'(status_bits[2:1]), 0);
  endtask

  task automatic t_lowbat;
    lowv_lvl = 1'b1;
    word_start = 1'b1;
    @(negedge clk);
    word_start = 1'b0;
    lowv_lvl = 1'b0;
    cyc(3);
    check("R3 flag captured at word start", int'(status_bits[0]), 1);
    lowv_lvl = 1'b1;
    cyc(2);
    lowv_lvl = 1'b0;
    word_start = 1'b1;
    @(negedge clk);
    word_start = 1'b0;
    check("R3 flag recaptured low", int'(status_bits[0]), 0);
  endtask

  task automatic t_time;
    crc_sel = 1'b0;
    buttons = 4'b0010;
    cyc(1);
    give_ticks(STEP - 1);
    check("R4 time bits before first step", int'(status_bits[2:1]), 0);
    give_ticks(1);
    check("R4 time bits after one step", int'(status_bits[2:1]), 1);
    give_ticks(STEP);
    check("R2 R4 time bits after two steps", int'(status_bits[2:1]), 2);
    give_ticks(3 * STEP);
    check("R4 time bits saturate", int'(status_bits[2:1]), 3);
    crc_sel = 1'b1;
    @(negedge clk);
    check("R2 select shows checksum", int'(status_bits[2:1]), 0);
    crc_sel = 1'b0;
    buttons = '0;
    @(negedge clk);
    check("R4 release clears time bits", int'(status_bits[2:1]), 0);
    give_ticks(QWIN);
  endtask

  task automatic press_release(input logic [NB-1:0] b);
    buttons = b;
    cyc(2);
    buttons = '0;
    cyc(1);
  endtask

  task automatic t_queue;
    crc_sel = 1'b0;
    press_release(4'b0101);
    for (int k = 1; k <= 4; k++) begin
      aborts = 0;
      buttons = 4'b0101;
      give_ticks(QSMP);
      check("R5 queue count after re-press", int'(status_bits[4:3]),
            (k > 3) ? 3 : k);
      check("R6 one abort pulse per re-press", aborts, 1);
      buttons = '0;
      cyc(1);
    end
    give_ticks(QWIN - 1);
    check("R7 count kept inside window", int'(status_bits[4:3]), 3);
    give_ticks(1);
    check("R7 window expiry clears count", int'(status_bits[4:3]), 0);
  endtask

  task automatic t_other;
    press_release(4'b0101);
    buttons = 4'b0101;
    give_ticks(QSMP);
    buttons = '0;
    cyc(1);
    check("R5 count one before other combo", int'(status_bits[4:3]), 1);
    aborts = 0;
    buttons = 4'b0011;
    give_ticks(QSMP);
    check("R8 other combination clears count", int'(status_bits[4:3]), 0);
    check("R8 no abort for other combination", aborts, 0);
    buttons = '0;
    cyc(1);
    give_ticks(QWIN);
  endtask

  task automatic t_gap;
    press_release(4'b1000);
    aborts = 0;
    give_ticks(1);
    buttons = 4'b1000;
    give_ticks(1);
    buttons = '0;
    give_ticks(QSMP - 2);
    check("R9 press between samples ignored", int'(status_bits[4:3]), 0);
    check("R9 no abort between samples", aborts, 0);
    buttons = 4'b1000;
    give_ticks(QSMP);
    check("R9 next sample counts press", int'(status_bits[4:3]), 1);
    check("R6 abort at sampled press", aborts, 1);
    buttons = '0;
    cyc(1);
    give_ticks(QWIN);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_crc();
    t_lowbat();
    t_time();
    t_queue();
    t_other();
    t_gap();
    cyc(4);
    finish_run();
  end
endmodule